// File: doc/BRIEF.md
# UART Transmitter with Selectable Empty Interrupt

This block is the transmit half of a UART. A host writes bytes into a one-byte holding register. When the serializer is idle, the holding register hands its byte to a frame shift register. The shift register then drives the TX line: one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts for one pulse of an externally generated baud tick. The line idles high.

A small control register lets software pick which event raises the transmit interrupt. The first choice is the moment the holding register gives its byte to the shifter. The second is the moment the last stop bit has left the line. The interrupt only fires while a separate enable input is high. A read-only bit in the same register shows that the shifter has drained and nothing is waiting. A break input holds the line low. While the break is held, the flag cannot become set and no new byte is started.

Top module: `uart_tx_irq`

## Requirements
- R1: After reset, the control readback is 0x02, TX is high, the holding register reports empty and the interrupt output is low.
- R2: A frame is sent on TX as one low start bit, then 8 data bits least significant first, then one high stop bit. TX advances by one bit per baud tick. Between frames TX is high.
- R3: A written byte makes the holding-empty output go low on the next cycle. If the shifter is idle and no break is active, the byte moves to the shifter one clock later. At that point the start bit appears and holding-empty returns high.
- R4: With control bit 0 = 0 and the enable high, the interrupt output rises when a byte moves from the holding register to the shifter.
- R5: With control bit 0 = 1 and the enable high, the interrupt output rises when the baud tick that ends the stop bit is taken. It does not rise on the transfer.
- R6: While the interrupt enable input is low, neither event raises the interrupt output.
- R7: The interrupt output is a level. It stays high until a holding-register write or a clear strobe. If an interrupt event and a clear fall in the same cycle, the interrupt stays high.
- R8: Control bit 1 (the shift-empty flag) is read-only. A holding-register write clears it. It is set one cycle after the shifter is idle, the holding register is empty and no break is active. Writing the control register changes only bit 0.
- R9: While the break input is high, TX is low and the shift-empty flag does not become set. A byte that is waiting stays in the holding register. When the break is released, TX returns high, or the waiting frame starts.
- R10: A write in the same cycle as a transfer keeps the new byte in the holding register. The shifter takes the old byte. The two bytes are sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse per bit period |
| dataWrEn | input | 1 | Holding-register write strobe |
| dataWrByte | input | 8 | Byte to write |
| ctlWrEn | input | 1 | Control-register write strobe |
| ctlWrVal | input | 8 | Control write value (only bit 0 is stored) |
| ctlRdVal | output | 8 | Control readback: bit 0 mode, bit 1 shift-empty |
| irqEnable | input | 1 | Transmit interrupt enable |
| irqClear | input | 1 | Interrupt clear strobe |
| breakReq | input | 1 | Hold TX low while high |
| txLine | output | 1 | Serial output |
| holdEmpty | output | 1 | Holding register can take a byte |
| txIrq | output | 1 | Transmit interrupt level |

## Verification
Two things can happen in the same cycle: a host write to the holding register, and the transfer of the previous byte into the shifter. The bench provokes this by issuing two writes on consecutive clocks into an idle block. The second write then lands on the clock that moves the first byte. The result is judged from three observations: holding-empty stays low, the start bit of the first byte appears, and both frames come out on TX in write order. In mode 0 the interrupt is also checked to stay high, because the transfer event wins over the clear caused by the write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes from the control side to the serializer
  typedef struct packed {
    logic load;  // take the holding byte and start a frame
    logic step;  // advance one bit period
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadByte,
  input  logic              breakReq,
  output logic              busy,
  output logic              frameEnd,
  output logic              txLine
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] shiftReg;
  logic [IDX_W-1:0]     bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitIdx   <= '0;
      busy     <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= {1'b1, loadByte, 1'b0};
      bitIdx   <= '0;
      busy     <= 1'b1;
    end else if (strobe.step && busy) begin
      shiftReg <= {1'b1, shiftReg[FRAME_LEN-1:1]};
      if (bitIdx == LAST_IDX) begin
        bitIdx <= '0;
        busy   <= 1'b0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  assign frameEnd = busy && strobe.step && (bitIdx == LAST_IDX);
  assign txLine   = !breakReq && (!busy || shiftReg[0]);

  // R3: the control side only starts a frame into an idle shifter
  p_load_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !busy);
  // R2: the last bit period of every frame is high
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !breakReq) |-> txLine);
  // R2: a new frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !breakReq) |-> !txLine);
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrByte,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrVal,
  input  logic              irqEnable,
  input  logic              irqClear,
  input  logic              breakReq,
  input  logic              busy,
  input  logic              frameEnd,
  output txStrobe_t         strobe,
  output logic [DATA_W-1:0] holdByte,
  output logic              holdEmpty,
  output logic [CTL_W-1:0]  ctlRdVal,
  output logic              txIrq
);
  localparam int MODE_BIT  = 0;
  localparam int EMPTY_BIT = 1;

  logic holdFull;
  logic drainMode;
  logic shiftEmpty;
  logic irqEvent;

  assign strobe.load = holdFull && !busy && !breakReq;
  assign strobe.step = baudTick;
  assign irqEvent    = drainMode ? frameEnd : strobe.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      holdFull <= 1'b0;
    end else if (dataWrEn) begin
      holdByte <= dataWrByte;
      holdFull <= 1'b1;
    end else if (strobe.load) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        drainMode <= 1'b0;
    else if (ctlWrEn) drainMode <= ctlWrVal[MODE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  shiftEmpty <= 1'b1;
    else if (dataWrEn)                          shiftEmpty <= 1'b0;
    else if (!busy && !holdFull && !breakReq)   shiftEmpty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      txIrq <= 1'b0;
    else if (irqEvent && irqEnable) txIrq <= 1'b1;
    else if (dataWrEn || irqClear)  txIrq <= 1'b0;
  end

  always_comb begin
    ctlRdVal            = '0;
    ctlRdVal[MODE_BIT]  = drainMode;
    ctlRdVal[EMPTY_BIT] = shiftEmpty;
  end

  assign holdEmpty = !holdFull;

  // R6: the interrupt only rises after a cycle with the enable high
  p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> $past(irqEnable));
  // R8: a holding write always clears the shift-empty flag
  p_write_clears_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |=> !ctlRdVal[EMPTY_BIT]);
  // R9: no flag set while a break is being sent
  p_break_no_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (breakReq && !ctlRdVal[EMPTY_BIT]) |=> !ctlRdVal[EMPTY_BIT]);
  // R3: a written byte is reported as pending
  p_hold_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |=> !holdEmpty);
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrByte,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrVal,
  output logic [CTL_W-1:0]  ctlRdVal,
  input  logic              irqEnable,
  input  logic              irqClear,
  input  logic              breakReq,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txIrq
);
  txStrobe_t         strobe;
  logic [DATA_W-1:0] holdByte;
  logic              busy;
  logic              frameEnd;

  uart_tx_ctrl #(.DATA_W(DATA_W), .CTL_W(CTL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .dataWrEn(dataWrEn), .dataWrByte(dataWrByte),
    .ctlWrEn(ctlWrEn), .ctlWrVal(ctlWrVal),
    .irqEnable(irqEnable), .irqClear(irqClear), .breakReq(breakReq),
    .busy(busy), .frameEnd(frameEnd),
    .strobe(strobe), .holdByte(holdByte), .holdEmpty(holdEmpty),
    .ctlRdVal(ctlRdVal), .txIrq(txIrq)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadByte(holdByte),
    .breakReq(breakReq), .busy(busy), .frameEnd(frameEnd), .txLine(txLine)
  );
endmodule

// File: tb/test_uart_tx_irq.sv
module test_uart_tx_irq;
  logic       clk = 1'b0;
  logic       rstN, baudTick, dataWrEn, ctlWrEn, irqEnable, irqClear, breakReq;
  logic [7:0] dataWrByte, ctlWrVal, ctlRdVal;
  logic       txLine, holdEmpty, txIrq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_irq i_uart_tx_irq (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .dataWrEn(dataWrEn),
    .dataWrByte(dataWrByte), .ctlWrEn(ctlWrEn), .ctlWrVal(ctlWrVal),
    .ctlRdVal(ctlRdVal), .irqEnable(irqEnable), .irqClear(irqClear),
    .breakReq(breakReq), .txLine(txLine), .holdEmpty(holdEmpty), .txIrq(txIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic writeByte(input logic [7:0] b);
    dataWrEn = 1'b1; dataWrByte = b;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic ctlWrite(input logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrVal = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic sendTick();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
  endtask

  task automatic pulseClear();
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
  endtask

  // Called with the start bit on the line; ends after the stop period
  task automatic checkFrame(input logic [7:0] b, input string req);
    chk({req, " start bit"}, txLine, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sendTick();
      chk({req, " data bit"}, txLine, b[i]);
    end
    sendTick();
    chk({req, " stop bit"}, txLine, 1'b1);
    sendTick();
    chk({req, " idle after stop"}, txLine, 1'b1);
  endtask

  task automatic testReset();
    chk("R1 ctl readback", ctlRdVal, 8'h02);
    chk("R1 tx idle", txLine, 1'b1);
    chk("R1 hold empty", holdEmpty, 1'b1);
    chk("R1 irq low", txIrq, 1'b0);
  endtask

  task automatic testTransferIrq();
    ctlWrite(8'h00);
    irqEnable = 1'b1;
    writeByte(8'hA5);
    chk("R3 hold full after write", holdEmpty, 1'b0);
    chk("R8 empty flag cleared by write", ctlRdVal[1], 1'b0);
    @(negedge clk);
    chk("R3 hold empty after transfer", holdEmpty, 1'b1);
    chk("R4 irq on transfer", txIrq, 1'b1);
    checkFrame(8'hA5, "R2");
    chk("R7 irq level held", txIrq, 1'b1);
    @(negedge clk);
    chk("R8 empty flag set after drain", ctlRdVal, 8'h02);
    pulseClear();
    chk("R7 clear strobe", txIrq, 1'b0);
  endtask

  task automatic testDrainIrq();
    ctlWrite(8'h01);
    chk("R8 ctl bit1 read-only", ctlRdVal, 8'h03);
    writeByte(8'h3C);
    @(negedge clk);
    chk("R5 no irq on transfer", txIrq, 1'b0);
    checkFrame(8'h3C, "R2");
    chk("R5 irq after stop bit", txIrq, 1'b1);
    writeByte(8'h81);
    chk("R7 write clears irq", txIrq, 1'b0);
    @(negedge clk);
    checkFrame(8'h81, "R2");
    chk("R5 irq after second frame", txIrq, 1'b1);
    pulseClear();
  endtask

  task automatic testEnableOff();
    ctlWrite(8'h00);
    irqEnable = 1'b0;
    writeByte(8'h5A);
    @(negedge clk);
    chk("R6 no irq with enable low", txIrq, 1'b0);
    checkFrame(8'h5A, "R2");
    chk("R6 still no irq", txIrq, 1'b0);
    irqEnable = 1'b1;
  endtask

  task automatic testBackToBack();
    writeByte(8'hC3);
    writeByte(8'h18);  // lands on the transfer of the first byte
    chk("R10 second byte held", holdEmpty, 1'b0);
    chk("R10 first frame started", txLine, 1'b0);
    chk("R7 event beats write clear", txIrq, 1'b1);
    checkFrame(8'hC3, "R10");
    @(negedge clk);
    chk("R10 second byte moved", holdEmpty, 1'b1);
    checkFrame(8'h18, "R10");
    pulseClear();
    @(negedge clk);
  endtask

  task automatic testBreak();
    writeByte(8'hE7);
    @(negedge clk);
    breakReq = 1'b1;
    #1;
    chk("R9 break drives low", txLine, 1'b0);
    for (int i = 0; i < 10; i++) sendTick();
    repeat (3) @(negedge clk);
    chk("R9 line low during break", txLine, 1'b0);
    chk("R9 no empty flag during break", ctlRdVal[1], 1'b0);
    breakReq = 1'b0;
    @(negedge clk);
    chk("R9 idle high after release", txLine, 1'b1);
    chk("R9 empty flag after release", ctlRdVal[1], 1'b1);
    breakReq = 1'b1;
    @(negedge clk);
    writeByte(8'h24);
    repeat (3) @(negedge clk);
    chk("R9 byte held during break", holdEmpty, 1'b0);
    chk("R9 line still low", txLine, 1'b0);
    breakReq = 1'b0;
    @(negedge clk);
    chk("R9 waiting byte starts", holdEmpty, 1'b1);
    checkFrame(8'h24, "R9");
    pulseClear();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; baudTick = 1'b0; dataWrEn = 1'b0; dataWrByte = '0;
    ctlWrEn = 1'b0; ctlWrVal = '0; irqEnable = 1'b0; irqClear = 1'b0;
    breakReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTransferIrq();
    testDrainIrq();
    testEnableOff();
    testBackToBack();
    testBreak();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule